// File: doc/BRIEF.md
# Configurable Stream Reduction Unit

The unit folds a stream of signed 32-bit samples into results with an operator chosen at configuration time. Each input beat carries one sample per lane. In free-axis mode every lane folds its own samples over a run whose length is the product of the element counts of the innermost one to four loop dimensions. In cross-lane mode each beat is first folded across the lanes, and the lane-folded values are then either emitted one per beat (channel form) or folded further over the whole four-dimension loop nest (all-axes form).

After the fold the result can be negated and then merged with a prior output value presented on a separate input, using the same operator. Average is a sum in which each element is first multiplied by a supplied reciprocal of the run length. The two modes have separate operator encodings and legality rules. An illegal configuration raises an error flag and silences the unit until a legal configuration arrives.

Top module: `stream_reduce_unit`

## Requirements
- R1: Axis codes 2, 3, 4 and 5 select free-axis mode and reduce code-1 dimensions. Count field 0 (bits 3:0) is the innermost dimension. Each lane emits one result for every run of extent beats, where extent is the product of the used counts. The result is valid in the cycle after the last beat of the run. A configuration write restarts the run count.
- R2: In free-axis mode the operator codes are add=0, sub=1, max=2, min=3, and=4, or=5, xor=6, avg=7, gt=8, ge=9, lt=10, le=11 and eq=12. Codes 13 to 15 are illegal.
- R3: In cross-lane mode the operator codes are add=0, avg=1, max=2, or=3, and=4 and xor=5. Codes 6 to 15 are illegal, so min, sub and the compares are rejected there.
- R4: A cross-lane configuration that requests negate is illegal.
- R5: Axis code 7 is the cross-lane channel form. Each beat is folded lane 0 upward and gives a result in lane 0 in the next cycle. Axis code 6 is the all-axes form: lane-folded values are folded further over the product of all four counts. In both forms result lanes above 0 read zero.
- R6: With avg, each element becomes (x*recip)>>>16 before it is added, where recip is an unsigned Q1.16 value (65536 = 1.0).
- R7: Negate applies to the folded value before the merge with the prior value. Negating the minimum integer gives the maximum integer.
- R8: With accumulate set, the result is op(post-negate value, prior). The prior is sampled on the last beat of the run, and avg merges by addition.
- R9: add, sub and avg saturate to the signed 32-bit range. and, or and xor act on the raw bits. A compare fold yields 1 or 0 from (running value op element).
- R10: Axis codes 0 and 1, a zero count in a used dimension, or any illegal operator set err_o from the next cycle. While the error holds, beats are ignored and no results appear. A legal configuration clears the error.
- R11: After reset err_o and res_valid_o are 0, and beats are ignored until the first configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | Configuration write strobe |
| cfg_axis_i | input | 3 | Axis and mode code |
| cfg_op_i | input | 4 | Operator code, mode-specific |
| cfg_neg_i | input | 1 | Negate the folded result |
| cfg_acc_i | input | 1 | Merge with the prior value |
| cfg_recip_i | input | 17 | Average reciprocal, Q1.16 |
| cfg_cnt_i | input | 4*CNT_W | Element counts of four dimensions, innermost first |
| in_valid_i | input | 1 | Sample beat valid |
| in_data_i | input | LANES*32 | Samples, lane 0 in low bits |
| prior_i | input | LANES*32 | Prior output values, sampled on the last beat |
| res_valid_o | output | 1 | Result valid, one cycle per result |
| res_data_o | output | LANES*32 | Results, lane 0 in low bits |
| err_o | output | 1 | Illegal configuration flag |

## Verification
A wrong run counter shows at once as results in the wrong cycle or with the wrong grouping. The effect is visible within one run of extent beats, so a partial run that is aborted by a reconfiguration is a pointed case. A faulty decode shows on err_o in the cycle after the configuration write, or as silence or output when the opposite is due. Mistakes in negate ordering, saturation or reciprocal scaling reach res_data_o in the cycle that ends a run. Extreme sample values and merges with a prior value bring them out.

// File: rtl/srsu_pkg.sv
package srsu_pkg;
  localparam int DATA_W = 32;
  localparam int REC_W  = 17;
  localparam int FRAC_W = 16;

  typedef logic signed [DATA_W-1:0] word_t;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MAX = 4'd2, OP_MIN = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_AVG = 4'd7,
    OP_GT  = 4'd8, OP_GE  = 4'd9, OP_LT  = 4'd10, OP_LE = 4'd11,
    OP_EQ  = 4'd12
  } red_op_e;

  localparam word_t WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam word_t WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic word_t sat_wide(input logic signed [DATA_W:0] s);
    if (s[DATA_W] != s[DATA_W-1]) return s[DATA_W] ? WORD_MIN : WORD_MAX;
    return s[DATA_W-1:0];
  endfunction

  function automatic word_t sat_add(input word_t a, input word_t b);
    logic signed [DATA_W:0] s;
    s = $signed({a[DATA_W-1], a}) + $signed({b[DATA_W-1], b});
    return sat_wide(s);
  endfunction

  function automatic word_t sat_sub(input word_t a, input word_t b);
    logic signed [DATA_W:0] s;
    s = $signed({a[DATA_W-1], a}) - $signed({b[DATA_W-1], b});
    return sat_wide(s);
  endfunction

  function automatic word_t sat_neg(input word_t a);
    return (a == WORD_MIN) ? WORD_MAX : -a;
  endfunction

  // element times Q1.16 reciprocal, floor shift, saturated
  function automatic word_t scale_word(input word_t x, input logic [REC_W-1:0] r);
    logic signed [DATA_W+REC_W:0] p;
    logic signed [DATA_W+REC_W:0] s;
    p = $signed({{(REC_W+1){x[DATA_W-1]}}, x}) * $signed({{DATA_W{1'b0}}, 1'b0, r});
    s = p >>> FRAC_W;
    if ((&s[DATA_W+REC_W:DATA_W-1]) || !(|s[DATA_W+REC_W:DATA_W-1]))
      return s[DATA_W-1:0];
    return s[DATA_W+REC_W] ? WORD_MIN : WORD_MAX;
  endfunction

  function automatic word_t red_apply(input red_op_e op, input word_t a, input word_t b);
    case (op)
      OP_ADD, OP_AVG: return sat_add(a, b);
      OP_SUB:         return sat_sub(a, b);
      OP_MAX:         return (a > b) ? a : b;
      OP_MIN:         return (a < b) ? a : b;
      OP_AND:         return a & b;
      OP_OR:          return a | b;
      OP_XOR:         return a ^ b;
      OP_GT:          return {{(DATA_W-1){1'b0}}, a > b};
      OP_GE:          return {{(DATA_W-1){1'b0}}, a >= b};
      OP_LT:          return {{(DATA_W-1){1'b0}}, a < b};
      OP_LE:          return {{(DATA_W-1){1'b0}}, a <= b};
      OP_EQ:          return {{(DATA_W-1){1'b0}}, a == b};
      default:        return a;
    endcase
  endfunction
endpackage

// File: rtl/srsu_cfg_decode.sv
module srsu_cfg_decode
  import srsu_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int EXT_W = 4 * CNT_W
) (
  input  logic [2:0]         axis_i,
  input  logic [3:0]         op_i,
  input  logic               neg_i,
  input  logic [4*CNT_W-1:0] cnt_i,
  output logic               legal_o,
  output logic               xlane_o,
  output logic               chan_o,
  output red_op_e            op_o,
  output logic [EXT_W-1:0]   extent_o
);
  localparam int DIMS = 4;
  logic [2:0] dims;

  always_comb begin
    legal_o  = 1'b1;
    xlane_o  = 1'b0;
    chan_o   = 1'b0;
    dims     = 3'd0;
    op_o     = OP_ADD;
    extent_o = {{(EXT_W-1){1'b0}}, 1'b1};
    case (axis_i)
      3'd2, 3'd3, 3'd4, 3'd5: dims = axis_i - 3'd1;
      3'd6: begin xlane_o = 1'b1; dims = 3'd4; end
      3'd7: begin xlane_o = 1'b1; chan_o = 1'b1; end
      default: legal_o = 1'b0;
    endcase
    for (int d = 0; d < DIMS; d++) begin
      if (3'(d) < dims) begin
        if (cnt_i[d*CNT_W +: CNT_W] == '0) legal_o = 1'b0;
        extent_o = extent_o * {{(EXT_W-CNT_W){1'b0}}, cnt_i[d*CNT_W +: CNT_W]};
      end
    end
    if (xlane_o) begin
      if (neg_i) legal_o = 1'b0;
      case (op_i)
        4'd0: op_o = OP_ADD;
        4'd1: op_o = OP_AVG;
        4'd2: op_o = OP_MAX;
        4'd3: op_o = OP_OR;
        4'd4: op_o = OP_AND;
        4'd5: op_o = OP_XOR;
        default: legal_o = 1'b0;
      endcase
    end else if (op_i > 4'd12) begin
      legal_o = 1'b0;
    end else begin
      op_o = red_op_e'(op_i);
    end
  end

  // R3: only the six lane-collapse operators survive decode in cross-lane mode
  always_comb begin
    if (legal_o && xlane_o)
      a_r3_xlane_op_set: assert (op_o inside {OP_ADD, OP_AVG, OP_MAX, OP_OR, OP_AND, OP_XOR});
  end
endmodule

// File: rtl/srsu_xlane_fold.sv
module srsu_xlane_fold
  import srsu_pkg::*;
#(
  parameter int LANES = 4
) (
  input  red_op_e                   op_i,
  input  logic [LANES*DATA_W-1:0]   vec_i,
  output word_t                     fold_o
);
  word_t part [LANES];

  assign part[0] = vec_i[DATA_W-1:0];
  for (genvar l = 1; l < LANES; l++) begin : g_chain
    assign part[l] = red_apply(op_i, part[l-1], vec_i[l*DATA_W +: DATA_W]);
  end
  assign fold_o = part[LANES-1];
endmodule

// File: rtl/srsu_lane_acc.sv
module srsu_lane_acc
  import srsu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    beat_i,
  input  logic    first_i,
  input  logic    last_i,
  input  red_op_e op_i,
  input  logic    neg_i,
  input  logic    acc_en_i,
  input  word_t   elem_i,
  input  word_t   prior_i,
  output word_t   res_o
);
  word_t acc_q, res_q, folded, post, fin;

  always_comb begin
    folded = first_i ? elem_i : red_apply(op_i, acc_q, elem_i);
    post   = neg_i ? sat_neg(folded) : folded;  // negate before merge
    fin    = acc_en_i ? red_apply(op_i, post, prior_i) : post;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (beat_i) begin
      acc_q <= folded;
      if (last_i) res_q <= fin;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/stream_reduce_unit.sv
module stream_reduce_unit
  import srsu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_valid_i,
  input  logic [2:0]              cfg_axis_i,
  input  logic [3:0]              cfg_op_i,
  input  logic                    cfg_neg_i,
  input  logic                    cfg_acc_i,
  input  logic [16:0]             cfg_recip_i,
  input  logic [4*CNT_W-1:0]      cfg_cnt_i,
  input  logic                    in_valid_i,
  input  logic [LANES*32-1:0]     in_data_i,
  input  logic [LANES*32-1:0]     prior_i,
  output logic                    res_valid_o,
  output logic [LANES*32-1:0]     res_data_o,
  output logic                    err_o
);
  localparam int EXT_W = 4 * CNT_W;
  localparam int VEC_W = LANES * DATA_W;

  logic             dec_legal, dec_xlane, dec_chan;
  red_op_e          dec_op;
  logic [EXT_W-1:0] dec_extent;

  srsu_cfg_decode #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_dec (
    .axis_i   (cfg_axis_i),
    .op_i     (cfg_op_i),
    .neg_i    (cfg_neg_i),
    .cnt_i    (cfg_cnt_i),
    .legal_o  (dec_legal),
    .xlane_o  (dec_xlane),
    .chan_o   (dec_chan),
    .op_o     (dec_op),
    .extent_o (dec_extent)
  );

  logic             cfg_ok_q, err_q, xlane_q, chan_q, neg_q, acc_en_q, res_valid_q;
  red_op_e          op_q;
  logic [REC_W-1:0] recip_q;
  logic [EXT_W-1:0] extent_q, cnt_q;
  logic             beat, first, last;

  assign beat  = in_valid_i && cfg_ok_q && !cfg_valid_i;
  assign first = (cnt_q == '0);
  assign last  = (cnt_q == extent_q - {{(EXT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_ok_q    <= 1'b0;
      err_q       <= 1'b0;
      xlane_q     <= 1'b0;
      chan_q      <= 1'b0;
      neg_q       <= 1'b0;
      acc_en_q    <= 1'b0;
      op_q        <= OP_ADD;
      recip_q     <= '0;
      extent_q    <= '0;
      cnt_q       <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= beat && last;
      if (cfg_valid_i) begin
        cfg_ok_q <= dec_legal;
        err_q    <= !dec_legal;
        xlane_q  <= dec_xlane;
        chan_q   <= dec_chan;
        neg_q    <= cfg_neg_i;
        acc_en_q <= cfg_acc_i;
        op_q     <= dec_op;
        recip_q  <= cfg_recip_i;
        extent_q <= dec_extent;
        cnt_q    <= '0;
      end else if (beat) begin
        cnt_q <= last ? '0 : cnt_q + {{(EXT_W-1){1'b0}}, 1'b1};
      end
    end
  end

  logic [VEC_W-1:0] scaled_v;
  word_t            tree_w;

  for (genvar l = 0; l < LANES; l++) begin : g_scale
    word_t raw;
    assign raw = in_data_i[l*DATA_W +: DATA_W];
    assign scaled_v[l*DATA_W +: DATA_W] = (op_q == OP_AVG) ? scale_word(raw, recip_q) : raw;
  end

  srsu_xlane_fold #(.LANES(LANES)) u_xfold (
    .op_i   (op_q),
    .vec_i  (scaled_v),
    .fold_o (tree_w)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    word_t lane_in, lane_pri, lane_res;
    assign lane_pri = prior_i[l*DATA_W +: DATA_W];
    if (l == 0) begin : g_head
      assign lane_in = xlane_q ? tree_w : scaled_v[DATA_W-1:0];
      assign res_data_o[DATA_W-1:0] = lane_res;
    end else begin : g_tail
      assign lane_in = scaled_v[l*DATA_W +: DATA_W];
      assign res_data_o[l*DATA_W +: DATA_W] = xlane_q ? '0 : lane_res;
    end
    srsu_lane_acc u_acc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .beat_i   (beat),
      .first_i  (first),
      .last_i   (last),
      .op_i     (op_q),
      .neg_i    (neg_q),
      .acc_en_i (acc_en_q),
      .elem_i   (lane_in),
      .prior_i  (lane_pri),
      .res_o    (lane_res)
    );
  end

  assign res_valid_o = res_valid_q;
  assign err_o       = err_q;

  a_r4_xlane_negate_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && (cfg_axis_i[2:1] == 2'b11) && cfg_neg_i |=> err_o);

  a_r10_silent_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !res_valid_o);

  a_r5_chan_every_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && cfg_ok_q && !cfg_valid_i && xlane_q && chan_q |=> res_valid_o);

  a_r1_no_early_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && cfg_ok_q && !cfg_valid_i && (cnt_q == '0) && (extent_q > 1) |=> !res_valid_o);

  a_r11_idle_unconfigured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok_q && !cfg_valid_i |=> !res_valid_o);
endmodule

// File: tb/stream_reduce_unit_tb.sv
module stream_reduce_unit_tb;
  localparam int LANES = 4;
  localparam int VW = LANES * 32;
  localparam int IMAX = 32'sh7fffffff;
  localparam int IMIN = 32'sh80000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 0, cfg_neg = 0, cfg_acc = 0, in_valid = 0;
  logic [2:0] cfg_axis = 0;
  logic [3:0] cfg_op = 0;
  logic [16:0] cfg_recip = 0;
  logic [15:0] cfg_cnt = 0;
  logic [VW-1:0] in_data = '0, prior = '0, res_data;
  logic res_valid, err;

  always #5 clk = ~clk;

  stream_reduce_unit #(.LANES(LANES), .CNT_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid), .cfg_axis_i(cfg_axis),
    .cfg_op_i(cfg_op), .cfg_neg_i(cfg_neg), .cfg_acc_i(cfg_acc), .cfg_recip_i(cfg_recip),
    .cfg_cnt_i(cfg_cnt), .in_valid_i(in_valid), .in_data_i(in_data), .prior_i(prior),
    .res_valid_o(res_valid), .res_data_o(res_data), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int dat [256][LANES];
  int pri [256][LANES];
  int m_axis, m_op, m_neg, m_acc, m_recip;
  int m_cnt [4];
  bit m_legal = 0;
  logic [VW-1:0] got_q [$];
  logic [VW-1:0] exp_q [$];
  int xl_map [6] = '{0, 7, 2, 5, 4, 6};

  always @(negedge clk) if (res_valid) got_q.push_back(res_data);

  task automatic chk(string req, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int b_sat(longint v);
    if (v > longint'(IMAX)) return IMAX;
    if (v < longint'(IMIN)) return IMIN;
    return int'(v);
  endfunction

  function automatic int b_apply(int op, int a, int b);
    case (op)
      0, 7: return b_sat(longint'(a) + longint'(b));
      1: return b_sat(longint'(a) - longint'(b));
      2: return (a > b) ? a : b;
      3: return (a < b) ? a : b;
      4: return a & b;
      5: return a | b;
      6: return a ^ b;
      8: return int'(a > b);
      9: return int'(a >= b);
      10: return int'(a < b);
      11: return int'(a <= b);
      default: return int'(a == b);
    endcase
  endfunction

  function automatic int b_scale(int x, int r);
    longint p = longint'(x) * longint'(r);
    return b_sat(p >>> 16);
  endfunction

  function automatic int b_neg(int a);
    return (a == IMIN) ? IMAX : -a;
  endfunction

  function automatic bit b_legal(int axis, int op, int neg, int c0, int c1, int c2, int c3);
    int c [4] = '{c0, c1, c2, c3};
    if (axis < 2) return 0;
    if (axis <= 5) begin
      if (op > 12) return 0;
      for (int d = 0; d < axis - 1; d++) if (c[d] == 0) return 0;
      return 1;
    end
    if (op > 5 || neg != 0) return 0;
    if (axis == 6) for (int d = 0; d < 4; d++) if (c[d] == 0) return 0;
    return 1;
  endfunction

  function automatic int elem(int iop, int x);
    return (iop == 7) ? b_scale(x, m_recip) : x;
  endfunction

  function automatic int beat_val(int iop, int b, int l);
    int v;
    if (m_axis <= 5) return elem(iop, dat[b][l]);
    v = elem(iop, dat[b][0]);
    for (int k = 1; k < LANES; k++) v = b_apply(iop, v, elem(iop, dat[b][k]));
    return v;
  endfunction

  task automatic build_exp(int nbeats);
    int iop, ext, nl;
    exp_q.delete();
    if (!m_legal) return;
    iop = (m_axis > 5) ? xl_map[m_op] : m_op;
    ext = 1;
    if (m_axis <= 5) for (int d = 0; d < m_axis - 1; d++) ext *= m_cnt[d];
    else if (m_axis == 6) for (int d = 0; d < 4; d++) ext *= m_cnt[d];
    nl = (m_axis > 5) ? 1 : LANES;
    for (int g = 0; g < nbeats / ext; g++) begin
      logic [VW-1:0] v = '0;
      for (int l = 0; l < nl; l++) begin
        int acc = beat_val(iop, g * ext, l);
        for (int j = 1; j < ext; j++) acc = b_apply(iop, acc, beat_val(iop, g * ext + j, l));
        if (m_neg != 0) acc = b_neg(acc);
        if (m_acc != 0) acc = b_apply(iop, acc, pri[g * ext + ext - 1][l]);
        v[l*32 +: 32] = acc;
      end
      exp_q.push_back(v);
    end
  endtask

  task automatic configure(string req, int axis, int op, int neg, int acc, int recip,
                           int c0, int c1, int c2, int c3);
    @(negedge clk);
    cfg_valid = 1; cfg_axis = 3'(axis); cfg_op = 4'(op); cfg_neg = neg[0]; cfg_acc = acc[0];
    cfg_recip = 17'(recip); cfg_cnt = {4'(c3), 4'(c2), 4'(c1), 4'(c0)};
    m_axis = axis; m_op = op; m_neg = neg; m_acc = acc; m_recip = recip;
    m_cnt = '{c0, c1, c2, c3};
    m_legal = b_legal(axis, op, neg, c0, c1, c2, c3);
    @(negedge clk);
    cfg_valid = 0;
    chk(req, "err flag after config", VW'(err), VW'(!m_legal));
  endtask

  task automatic run_case(string req, int nbeats);
    got_q.delete();
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      in_valid = 1;
      for (int l = 0; l < LANES; l++) begin
        in_data[l*32 +: 32] = dat[b][l];
        prior[l*32 +: 32] = pri[b][l];
      end
    end
    @(negedge clk);
    in_valid = 0;
    repeat (2) @(negedge clk);
    build_exp(nbeats);
    chk(req, "result count", VW'(got_q.size()), VW'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(req, $sformatf("result %0d", i), got_q[i], exp_q[i]);
  endtask

  function automatic int rnd_word();
    case ($urandom % 8)
      0: return IMAX;
      1: return IMIN;
      2: return int'($urandom);
      default: return int'($urandom % 2001) - 1000;
    endcase
  endfunction

  task automatic fill_rand(int nbeats);
    for (int b = 0; b < nbeats; b++)
      for (int l = 0; l < LANES; l++) begin
        dat[b][l] = rnd_word();
        pri[b][l] = rnd_word();
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "err after reset", VW'(err), '0);
    chk("R11", "valid after reset", VW'(res_valid), '0);
    fill_rand(8);
    run_case("R11", 8);

    // R1: two dims of 2x3 -> extent 6
    configure("R1", 3, 0, 0, 0, 0, 2, 3, 0, 0);
    for (int b = 0; b < 12; b++) for (int l = 0; l < LANES; l++) begin
      dat[b][l] = b * 10 + l; pri[b][l] = 0;
    end
    run_case("R1", 12);
    // R1: aborted partial run restarts on reconfiguration
    run_case("R1", 3);
    configure("R1", 3, 0, 0, 0, 0, 2, 3, 0, 0);
    run_case("R1", 6);
    configure("R1", 5, 2, 0, 0, 0, 2, 1, 2, 2);
    fill_rand(16);
    run_case("R1", 16);

    // R2: free-axis sub, min, compares; illegal code 13
    configure("R2", 2, 1, 0, 0, 0, 4, 0, 0, 0);
    fill_rand(8); run_case("R2", 8);
    configure("R2", 2, 3, 0, 0, 0, 3, 0, 0, 0);
    fill_rand(6); run_case("R2", 6);
    configure("R2", 2, 9, 0, 0, 0, 3, 0, 0, 0);
    for (int b = 0; b < 3; b++) for (int l = 0; l < LANES; l++) dat[b][l] = l - b;
    run_case("R2", 3);
    configure("R2", 2, 13, 0, 0, 0, 3, 0, 0, 0);
    run_case("R2", 3);

    // R3: cross-lane rejects min and code 6, accepts max
    configure("R3", 7, 6, 0, 0, 0, 1, 1, 1, 1);
    configure("R3", 7, 2, 0, 0, 0, 1, 1, 1, 1);
    fill_rand(5); run_case("R3", 5);

    // R4 + R10: cross-lane negate is illegal and silences the unit
    configure("R4", 7, 0, 1, 0, 0, 1, 1, 1, 1);
    fill_rand(4); run_case("R10", 4);
    configure("R10", 1, 0, 0, 0, 0, 2, 2, 2, 2);
    configure("R10", 4, 0, 0, 0, 0, 2, 0, 2, 2);
    run_case("R10", 4);
    configure("R10", 2, 0, 0, 0, 0, 2, 0, 0, 0);
    run_case("R10", 4);

    // R5: channel form per beat; all-axes form over 2*1*2*1 beats
    configure("R5", 7, 0, 0, 0, 0, 0, 0, 0, 0);
    fill_rand(6); run_case("R5", 6);
    configure("R5", 6, 5, 0, 0, 0, 2, 1, 2, 1);
    fill_rand(8); run_case("R5", 8);

    // R6: average with reciprocal 1/3, free and cross-lane
    configure("R6", 2, 7, 0, 0, 21845, 3, 0, 0, 0);
    for (int b = 0; b < 6; b++) for (int l = 0; l < LANES; l++) dat[b][l] = 300 * (l + 1) - 7 * b;
    run_case("R6", 6);
    configure("R6", 6, 1, 0, 0, 16384, 2, 1, 1, 1);
    fill_rand(4); run_case("R6", 4);

    // R7 + R8: negate then merge with prior, sub merge shows the order
    configure("R7", 2, 1, 1, 1, 0, 2, 0, 0, 0);
    for (int l = 0; l < LANES; l++) begin
      dat[0][l] = 8; dat[1][l] = 3; pri[0][l] = 0; pri[1][l] = 2 + l;
    end
    run_case("R7", 2);
    configure("R7", 2, 0, 1, 0, 0, 1, 0, 0, 0);
    for (int l = 0; l < LANES; l++) dat[0][l] = (l == 0) ? IMIN : -l;
    run_case("R7", 1);
    configure("R8", 2, 2, 0, 1, 0, 2, 0, 0, 0);
    fill_rand(4); run_case("R8", 4);
    configure("R8", 7, 1, 0, 1, 32768, 0, 0, 0, 0);
    fill_rand(4); run_case("R8", 4);

    // R9: saturation and raw bitwise
    configure("R9", 2, 0, 0, 0, 0, 2, 0, 0, 0);
    for (int l = 0; l < LANES; l++) begin
      dat[0][l] = (l < 2) ? IMAX : IMIN; dat[1][l] = (l < 2) ? 5 : -5;
    end
    run_case("R9", 2);
    configure("R9", 2, 4, 0, 0, 0, 2, 0, 0, 0);
    fill_rand(4); run_case("R9", 4);

    // random legal and illegal configurations
    for (int it = 0; it < 40; it++) begin
      int mode = $urandom % 3;
      int axis = (mode == 0) ? 2 + int'($urandom % 4) : 6 + mode - 1;
      int op = (mode == 0) ? int'($urandom % 14) : int'($urandom % 7);
      int neg = (mode == 0) ? int'($urandom % 2) : 0;
      int c0 = 1 + $urandom % 3, c1 = 1 + $urandom % 3, c2 = 1 + $urandom % 3, c3 = 1 + $urandom % 3;
      int nb = 2 * c0 * c1 * c2 * c3;
      configure("R2", axis, op, neg, int'($urandom % 2), int'($urandom % 65537), c0, c1, c2, c3);
      fill_rand(nb);
      run_case((mode == 0) ? "R1" : "R5", nb);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule